// File: doc/BRIEF.md
# I/O Address Translation Table Walker

This block turns a device-side virtual address into a physical address by walking a radix page table kept in memory. Each table is 4 KiB and holds 512 eight-byte entries, so every level resolves 9 address bits above the 12-bit page offset. A 4-bit mode code picks the depth of the walk. Code 8 gives a 39-bit space and starts at level 2. Code 9 gives 48 bits and starts at level 3. Code 10 gives 57 bits and starts at level 4.

A request presents the virtual address, the mode, the root table page number and a flag that enables 64 KiB contiguous leaves. The walker then issues one 64-bit entry read per level on a valid/ready read-request port and takes the entry back on a valid/ready data port. A leaf may appear at any level. At the end, the walker returns a one-cycle response. The response carries either the physical address and the leaf's permission bits, or a fault cause. Only one walk is in progress at a time.

Entry layout relied on throughout: bit 0 valid, bits 1/2/3 read/write/execute, bits 7:4 user/global/accessed/dirty, bits 53:10 page number (PPN), bit 63 contiguous-64K marker (N). Fault cause codes: 0 none, 1 bad mode, 2 non-canonical address, 3 invalid entry, 4 misaligned large leaf, 5 illegal 64K marker.

Top module: `iova_walker`

## Requirements
- R1: Mode codes 8, 9 and 10 start the walk at level mode-6. The first read address is root_ppn×4096 plus 8 times the 9-bit address index of that level. The sign-extended address of each mode translates correctly.
- R2: Any mode code other than 8, 9 or 10 makes the walker respond with fault cause 1. It issues no memory read, and rsp_valid_o rises in the cycle after the request is accepted.
- R3: When the address bits from the top implemented bit (38, 47 or 56) up to bit 63 are not all equal, the walker responds with cause 2. It issues no read, and the response comes in the cycle after acceptance.
- R4: The entry read for level L uses the address table_base + 8×VA[20+9L:12+9L], which is always 8-byte aligned. A valid non-leaf entry sets the next table base to PPN×4096 and moves the walk down one level.
- R5: An entry with bit 0 clear ends the walk with cause 3.
- R6: An entry is a leaf when it sits at level 0 or when any of bits 1..3 is set. A level-0 leaf returns {PPN, VA[11:0]}. Every successful leaf reports entry bits 7:1 as the permission output.
- R7: A leaf at level L>0 maps 4 KiB×512^L. Its output address takes the PPN's upper bits and VA bits [11+9L:0]. If PPN bits [9L-1:0] are not zero, the walk ends with cause 4.
- R8: With 64K support enabled, a level-0 leaf with bit 63 set and PPN[3:0]=1000 returns {entry[53:14], VA[15:0]}.
- R9: When bit 63 is set on a valid entry above level 0, or while 64K support is off, or with PPN[3:0]≠1000, the walk ends with cause 5.
- R10: req_ready_o drops from the acceptance cycle until the response. rsp_valid_o is a one-cycle pulse, and req_ready_o is high again in the cycle after it.
- R11: A read request stays asserted with a stable address until it is accepted. mem_rsp_ready_o is high only while no read request is pending and no walk request can be taken.
- R12: A fault response reports zero for the physical address and the permissions. A successful response reports cause 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request accepted when valid |
| req_va_i | input | 64 | Virtual address to translate |
| mode_i | input | 4 | Address-space mode code |
| root_ppn_i | input | 44 | Page number of the root table |
| napot_en_i | input | 1 | Enables 64 KiB contiguous leaves |
| mem_req_valid_o | output | 1 | Entry read request valid |
| mem_req_ready_i | input | 1 | Memory accepts the read request |
| mem_req_addr_o | output | 56 | Physical byte address of the entry |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_ready_o | output | 1 | Walker waiting for read data |
| mem_rsp_data_i | input | 64 | Entry read from memory |
| rsp_valid_o | output | 1 | One-cycle translation response |
| rsp_fault_o | output | 1 | Response is a fault |
| rsp_cause_o | output | 3 | Fault cause code (0 none) |
| rsp_pa_o | output | 56 | Translated physical address |
| rsp_perm_o | output | 7 | Leaf bits 7:1 (R, W, X, U, G, A, D) |

## Verification
The assertions hold on every cycle for the handshake rules of the walker. They cover the busy window after acceptance, the single-cycle response, a read request held stable while stalled, entry alignment, zero data on faults, and the immediate fault for an unsupported mode. The correctness of the translated address, the permission bits and the choice among the deeper fault causes depends on table contents in memory. Only the bench scenarios show these: large leaves at several levels, misaligned PPNs, 64K leaves with and without support, invalid entries mid-walk and non-canonical addresses. These run under random memory stalls and are compared with an independent walk model.

// File: rtl/iova_walk_pkg.sv
package iova_walk_pkg;
  localparam int unsigned PTE_W   = 64;
  localparam int unsigned PTE_V   = 0;
  localparam int unsigned PTE_R   = 1;
  localparam int unsigned PTE_W_B = 2;
  localparam int unsigned PTE_X   = 3;
  localparam int unsigned PTE_N   = 63;
  localparam int unsigned PPN_LSB = 10;

  typedef enum logic [2:0] {
    CAUSE_NONE     = 3'd0,
    CAUSE_MODE     = 3'd1,
    CAUSE_CANON    = 3'd2,
    CAUSE_INVALID  = 3'd3,
    CAUSE_MISALIGN = 3'd4,
    CAUSE_NAPOT    = 3'd5
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/iova_mode_check.sv
module iova_mode_check #(
  parameter int unsigned VA_W    = 64,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned MODE_W  = 4,
  parameter int unsigned LVL_W   = 3,
  parameter int          MODE_LO = 8,
  parameter int          MODE_HI = 10,
  parameter int          LVL_OFS = 6
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [VA_W-1:0]   va_i,
  output logic              mode_ok_o,
  output logic [LVL_W-1:0]  top_lvl_o,
  output logic              canon_ok_o
);
  int unsigned va_bits;
  logic [VA_W-1:0] upper, ones;

  always_comb begin
    mode_ok_o  = (int'(mode_i) >= MODE_LO) && (int'(mode_i) <= MODE_HI);
    top_lvl_o  = mode_ok_o ? LVL_W'(int'(mode_i) - LVL_OFS) : '0;
    va_bits    = OFF_W + IDX_W * (32'(top_lvl_o) + 32'd1);
    // bits from the top implemented one upward must all match it
    upper      = va_i >> (va_bits - 1);
    ones       = {VA_W{1'b1}} >> (va_bits - 1);
    canon_ok_o = (upper == '0) || (upper == ones);
  end
endmodule

// File: rtl/iova_entry_addr.sv
module iova_entry_addr #(
  parameter int unsigned VA_W    = 64,
  parameter int unsigned PA_W    = 56,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned IDX_W   = 9,
  parameter int unsigned LVL_W   = 3,
  parameter int unsigned ENT_LG2 = 3
) (
  input  logic [PA_W-1:0]  base_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [VA_W-1:0]  va_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx    = IDX_W'(va_i >> (OFF_W + IDX_W * 32'(lvl_i)));
    addr_o = base_i + PA_W'({idx, {ENT_LG2{1'b0}}});
  end
endmodule

// File: rtl/iova_pte_eval.sv
module iova_pte_eval
  import iova_walk_pkg::*;
#(
  parameter int unsigned VA_W      = 64,
  parameter int unsigned PA_W      = 56,
  parameter int unsigned PPN_W     = 44,
  parameter int unsigned OFF_W     = 12,
  parameter int unsigned IDX_W     = 9,
  parameter int unsigned LVL_W     = 3,
  parameter int unsigned NAPOT_LG2 = 16
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [VA_W-1:0]  va_i,
  input  logic             napot_en_i,
  output logic             valid_o,
  output logic             leaf_o,
  output logic             napot_bad_o,
  output logic             misalign_o,
  output logic [PA_W-1:0]  leaf_pa_o,
  output logic [PA_W-1:0]  next_base_o,
  output logic [6:0]       perm_o
);
  localparam int unsigned NAP_PPN = NAPOT_LG2 - OFF_W;

  logic [PPN_W-1:0] ppn, ppn_lo_mask;
  logic [PA_W-1:0]  page_pa, va_pa, off_mask, nap_mask;
  logic             is_n, code_ok;
  logic             unused_bits;

  assign unused_bits = ^{pte_i[PTE_N-1:PPN_LSB+PPN_W], pte_i[PPN_LSB-1:8]};

  always_comb begin
    ppn         = pte_i[PPN_LSB +: PPN_W];
    is_n        = pte_i[PTE_N];
    page_pa     = PA_W'({ppn, {OFF_W{1'b0}}});
    va_pa       = PA_W'(va_i);
    off_mask    = (PA_W'(1) << (OFF_W + IDX_W * 32'(lvl_i))) - PA_W'(1);
    nap_mask    = (PA_W'(1) << NAPOT_LG2) - PA_W'(1);
    ppn_lo_mask = (PPN_W'(1) << (IDX_W * 32'(lvl_i))) - PPN_W'(1);
    code_ok     = ppn[NAP_PPN-1:0] == NAP_PPN'(1 << (NAP_PPN - 1));

    valid_o     = pte_i[PTE_V];
    leaf_o      = (lvl_i == '0) || pte_i[PTE_R] || pte_i[PTE_W_B] || pte_i[PTE_X];
    napot_bad_o = is_n && ((lvl_i != '0) || !napot_en_i || !code_ok);
    misalign_o  = (lvl_i != '0) && ((ppn & ppn_lo_mask) != '0);
    if (is_n) leaf_pa_o = (page_pa & ~nap_mask) | (va_pa & nap_mask);
    else      leaf_pa_o = (page_pa & ~off_mask) | (va_pa & off_mask);
    next_base_o = page_pa;
    perm_o      = pte_i[7:1];
  end
endmodule

// File: rtl/iova_walker.sv
module iova_walker
  import iova_walk_pkg::*;
#(
  parameter int unsigned VA_W   = 64,
  parameter int unsigned PA_W   = 56,
  parameter int unsigned PPN_W  = 44,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned MODE_W = 4,
  parameter int unsigned LVL_W  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [VA_W-1:0]   req_va_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [PPN_W-1:0]  root_ppn_i,
  input  logic              napot_en_i,
  output logic              mem_req_valid_o,
  input  logic              mem_req_ready_i,
  output logic [PA_W-1:0]   mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  output logic              mem_rsp_ready_o,
  input  logic [PTE_W-1:0]  mem_rsp_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_fault_o,
  output logic [2:0]        rsp_cause_o,
  output logic [PA_W-1:0]   rsp_pa_o,
  output logic [6:0]        rsp_perm_o
);
  walk_st_e         st_q;
  cause_e           cause_q;
  logic [VA_W-1:0]  va_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  base_q, pa_q;
  logic [6:0]       perm_q;
  logic             napot_q;

  logic             mode_ok, canon_ok;
  logic [LVL_W-1:0] top_lvl;
  logic             e_valid, e_leaf, e_napot_bad, e_misalign;
  logic [PA_W-1:0]  e_leaf_pa, e_next_base;
  logic [6:0]       e_perm;

  iova_mode_check #(
    .VA_W(VA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .MODE_W(MODE_W), .LVL_W(LVL_W)
  ) u_mode (
    .mode_i(mode_i), .va_i(req_va_i),
    .mode_ok_o(mode_ok), .top_lvl_o(top_lvl), .canon_ok_o(canon_ok)
  );

  iova_entry_addr #(
    .VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LVL_W(LVL_W)
  ) u_addr (
    .base_i(base_q), .lvl_i(lvl_q), .va_i(va_q), .addr_o(mem_req_addr_o)
  );

  iova_pte_eval #(
    .VA_W(VA_W), .PA_W(PA_W), .PPN_W(PPN_W), .OFF_W(OFF_W), .IDX_W(IDX_W), .LVL_W(LVL_W)
  ) u_eval (
    .pte_i(mem_rsp_data_i), .lvl_i(lvl_q), .va_i(va_q), .napot_en_i(napot_q),
    .valid_o(e_valid), .leaf_o(e_leaf), .napot_bad_o(e_napot_bad),
    .misalign_o(e_misalign), .leaf_pa_o(e_leaf_pa), .next_base_o(e_next_base),
    .perm_o(e_perm)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cause_q <= CAUSE_NONE;
      va_q    <= '0;
      lvl_q   <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      perm_q  <= '0;
      napot_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          va_q    <= req_va_i;
          napot_q <= napot_en_i;
          lvl_q   <= top_lvl;
          base_q  <= PA_W'({root_ppn_i, {OFF_W{1'b0}}});
          pa_q    <= '0;
          perm_q  <= '0;
          // R2/R3: reject before any memory traffic
          if (!mode_ok) begin
            cause_q <= CAUSE_MODE;
            st_q    <= ST_RESP;
          end else if (!canon_ok) begin
            cause_q <= CAUSE_CANON;
            st_q    <= ST_RESP;
          end else begin
            cause_q <= CAUSE_NONE;
            st_q    <= ST_ISSUE;
          end
        end
        ST_ISSUE: if (mem_req_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (!e_valid) begin
            cause_q <= CAUSE_INVALID;
            st_q    <= ST_RESP;
          end else if (e_napot_bad) begin
            cause_q <= CAUSE_NAPOT;
            st_q    <= ST_RESP;
          end else if (e_leaf) begin
            st_q <= ST_RESP;
            if (e_misalign) begin
              cause_q <= CAUSE_MISALIGN;
            end else begin
              pa_q   <= e_leaf_pa;
              perm_q <= e_perm;
            end
          end else begin
            base_q <= e_next_base;
            lvl_q  <= lvl_q - LVL_W'(1);
            st_q   <= ST_ISSUE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (st_q == ST_IDLE);
  assign mem_req_valid_o = (st_q == ST_ISSUE);
  assign mem_rsp_ready_o = (st_q == ST_WAIT);
  assign rsp_valid_o     = (st_q == ST_RESP);
  assign rsp_fault_o     = (cause_q != CAUSE_NONE);
  assign rsp_cause_o     = cause_q;
  assign rsp_pa_o        = pa_q;
  assign rsp_perm_o      = perm_q;
endmodule

// File: rtl/iova_walker_chk.sv
module iova_walker_chk #(
  parameter int unsigned VA_W   = 64,
  parameter int unsigned PA_W   = 56,
  parameter int unsigned MODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [MODE_W-1:0] mode_i,
  input logic              mem_req_valid_o,
  input logic              mem_req_ready_i,
  input logic [PA_W-1:0]   mem_req_addr_o,
  input logic              mem_rsp_ready_o,
  input logic              rsp_valid_o,
  input logic              rsp_fault_o,
  input logic [2:0]        rsp_cause_o,
  input logic [PA_W-1:0]   rsp_pa_o,
  input logic [6:0]        rsp_perm_o
);
  logic bad_mode;
  assign bad_mode = (mode_i != 4'd8) && (mode_i != 4'd9) && (mode_i != 4'd10);

  a_r2_mode_fault: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && bad_mode |=>
      rsp_valid_o && rsp_fault_o && (rsp_cause_o == 3'd1) && !mem_req_valid_o);

  a_r4_entry_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> (mem_req_addr_o[2:0] == 3'b000));

  a_r10_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  a_r10_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o && req_ready_o);

  a_r11_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o));

  a_r11_rsp_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rsp_ready_o |-> !mem_req_valid_o && !req_ready_o);

  a_r12_fault_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> (rsp_pa_o == '0) && (rsp_perm_o == '0));

  a_r12_ok_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o |-> (rsp_cause_o == 3'd0));
endmodule

bind iova_walker iova_walker_chk u_chk (.*);

// File: tb/iova_walker_tb.sv
`timescale 1ns/1ps
module iova_walker_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [63:0] req_va_i = '0;
  logic [3:0]  mode_i = '0;
  logic [43:0] root_ppn_i = '0;
  logic        napot_en_i = 1'b0;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i = 1'b0;
  logic [55:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic        mem_rsp_ready_o;
  logic [63:0] mem_rsp_data_i = '0;
  logic        rsp_valid_o;
  logic        rsp_fault_o;
  logic [2:0]  rsp_cause_o;
  logic [55:0] rsp_pa_o;
  logic [6:0]  rsp_perm_o;

  int n_chk = 0;
  int n_bad = 0;
  int reads = 0;
  logic [63:0] mem [logic [55:0]];

  always #2.5 clk_i = ~clk_i;

  iova_walker u_dut (.*);

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [55:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  function automatic logic [63:0] sext(input logic [63:0] raw, input int vab);
    return 64'($signed(raw << (64 - vab)) >>> (64 - vab));
  endfunction

  function automatic logic [63:0] mk_pte(input logic [43:0] ppn, input logic [6:0] perm, input bit n);
    return {n, 9'h0, ppn, 2'b00, perm, 1'b1};
  endfunction

  // independent walk model built from the requirements
  function automatic void model(input logic [63:0] va, input logic [3:0] mode,
                                input logic [43:0] root, input bit nap,
                                output logic [55:0] pa, output logic [6:0] perm,
                                output logic [2:0] cause, output int nrd);
    int lvl;
    int vab;
    logic [55:0] base;
    logic [63:0] pte;
    logic [43:0] ppn;
    pa = '0; perm = '0; cause = 3'd0; nrd = 0;
    if (mode < 4'd8 || mode > 4'd10) begin cause = 3'd1; return; end
    lvl = int'(mode) - 6;
    vab = 12 + 9 * (lvl + 1);
    if (sext(va, vab) != va) begin cause = 3'd2; return; end
    base = {root, 12'h0};
    for (int k = 0; k < 6; k++) begin
      pte = rd(base + 56'(((va >> (12 + 9 * lvl)) & 64'd511) * 8));
      nrd++;
      ppn = pte[53:10];
      if (!pte[0]) begin cause = 3'd3; return; end
      if (pte[63] && (lvl != 0 || !nap || ppn[3:0] != 4'b1000)) begin cause = 3'd5; return; end
      if (lvl == 0 || pte[3:1] != 3'b000) begin
        if (lvl > 0 && (ppn % (44'd1 << (9 * lvl))) != 0) begin cause = 3'd4; return; end
        if (pte[63]) pa = {pte[53:14], va[15:0]};
        else pa = (({ppn, 12'h0} >> (12 + 9 * lvl)) << (12 + 9 * lvl)) |
                  (va[55:0] & ((56'd1 << (12 + 9 * lvl)) - 56'd1));
        perm = pte[7:1];
        return;
      end
      base = {ppn, 12'h0};
      lvl--;
    end
  endfunction

  // builds the chain of tables to leaf_lvl and places leaf there
  task automatic build(input logic [63:0] va, input logic [3:0] mode, input logic [43:0] root,
                       input int leaf_lvl, input logic [63:0] leaf);
    int lvl;
    logic [55:0] base;
    logic [43:0] nppn;
    mem.delete();
    lvl = int'(mode) - 6;
    base = {root, 12'h0};
    while (lvl > leaf_lvl) begin
      nppn = {12'h0, $urandom};
      mem[base + 56'(((va >> (12 + 9 * lvl)) & 64'd511) * 8)] = {10'h0, nppn, 10'h001};
      base = {nppn, 12'h0};
      lvl--;
    end
    mem[base + 56'(((va >> (12 + 9 * lvl)) & 64'd511) * 8)] = leaf;
  endtask

  task automatic run(input logic [63:0] va, input logic [3:0] mode, input logic [43:0] root,
                     input bit nap, input string tag);
    logic [55:0] e_pa;
    logic [6:0]  e_perm;
    logic [2:0]  e_cause;
    int e_rd;
    int lat;
    bit busy_ok;
    model(va, mode, root, nap, e_pa, e_perm, e_cause, e_rd);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_va_i = va; mode_i = mode; root_ppn_i = root; napot_en_i = nap;
    reads = 0;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    lat = 0; busy_ok = 1'b1;
    while (!rsp_valid_o && lat < 400) begin
      if (req_ready_o) busy_ok = 1'b0;
      @(negedge clk_i);
      lat++;
    end
    chk(rsp_valid_o == 1'b1, tag, "response", 64'(rsp_valid_o), 64'd1);
    chk(rsp_cause_o == e_cause, tag, "cause", 64'(rsp_cause_o), 64'(e_cause));
    chk(rsp_fault_o == (e_cause != 3'd0), tag, "fault", 64'(rsp_fault_o), 64'(e_cause != 3'd0));
    chk(rsp_pa_o == e_pa, tag, "pa", 64'(rsp_pa_o), 64'(e_pa));
    chk(rsp_perm_o == e_perm, tag, "perm", 64'(rsp_perm_o), 64'(e_perm));
    chk(reads == e_rd, tag, "reads", 64'(reads), 64'(e_rd));
    if (e_rd == 0) chk(lat == 0, tag, "latency", 64'(lat), 64'd0);
    @(negedge clk_i);
    chk(busy_ok && req_ready_o && !rsp_valid_o, "R10", "ready/pulse",
        64'({busy_ok, req_ready_o, rsp_valid_o}), 64'b110);
  endtask

  // memory model with random stalls
  initial begin
    forever begin
      logic [55:0] a;
      @(negedge clk_i);
      mem_req_ready_i = 1'($urandom % 2);
      if (rst_ni && mem_req_valid_o && mem_req_ready_i) begin
        a = mem_req_addr_o;
        reads++;
        @(negedge clk_i);
        mem_req_ready_i = 1'b0;
        repeat ($urandom % 3) @(negedge clk_i);
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i = rd(a);
        @(negedge clk_i);
        mem_rsp_valid_i = 1'b0;
        mem_rsp_data_i = '0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [63:0] va;
    logic [43:0] root;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !mem_req_valid_o && !rsp_valid_o && !mem_rsp_ready_o, "R10", "reset state",
        64'({req_ready_o, mem_req_valid_o, rsp_valid_o, mem_rsp_ready_o}), 64'b1000);
    rst_ni = 1'b1;

    root = 44'h0_0012_3456;
    // R2: unsupported modes
    run(64'h1000, 4'd7, root, 1'b0, "R2");
    run(64'h1000, 4'd11, root, 1'b0, "R2");
    run(64'h1000, 4'd0, root, 1'b0, "R2");
    // R3: non-canonical addresses
    run(64'h0000_0040_0000_0000, 4'd8, root, 1'b0, "R3");
    run(64'h8000_0000_0000_0000, 4'd10, root, 1'b0, "R3");
    // R1/R6/R4: 4K leaves in every mode
    for (int m = 8; m <= 10; m++) begin
      va = sext({$urandom, $urandom}, 12 + 9 * (m - 5));
      build(va, 4'(m), root, 0, mk_pte(44'h0_00AB_CDEF, 7'h65, 1'b0));
      run(va, 4'(m), root, 1'b0, "R1");
    end
    va = 64'hFFFF_8000_0000_1000;
    build(va, 4'd9, root, 0, mk_pte(44'h0_0000_7777, 7'h01, 1'b0));
    run(va, 4'd9, root, 1'b0, "R1");
    // R6: level-0 entry with R/W/X clear is still a leaf
    va = 64'h0000_0012_3456_7ABC;
    build(va, 4'd8, root, 0, mk_pte(44'h0_0000_4321, 7'h00, 1'b0));
    run(va, 4'd8, root, 1'b0, "R6");
    // R7: large leaves aligned and misaligned
    build(va, 4'd8, root, 1, mk_pte(44'h0_0003_0000 & ~44'h1FF, 7'h03, 1'b0));
    run(va, 4'd8, root, 1'b0, "R7");
    build(va, 4'd10, root, 2, mk_pte(44'h0_0100_0000, 7'h07, 1'b0));
    run(va, 4'd10, root, 1'b0, "R7");
    build(va, 4'd8, root, 2, mk_pte(44'h0_0100_0200, 7'h03, 1'b0));
    run(va, 4'd8, root, 1'b0, "R7");
    // R5: invalid leaf and invalid mid-walk
    build(va, 4'd9, root, 0, 64'h0);
    run(va, 4'd9, root, 1'b0, "R5");
    build(va, 4'd9, root, 2, mk_pte(44'h0_0000_1000, 7'h00, 1'b0) & ~64'h1);
    run(va, 4'd9, root, 1'b0, "R5");
    // R8/R9: 64K contiguous leaves
    build(va, 4'd8, root, 0, mk_pte(44'h0_0005_5558, 7'h0B, 1'b1));
    run(va, 4'd8, root, 1'b1, "R8");
    run(va, 4'd8, root, 1'b0, "R9");
    build(va, 4'd8, root, 0, mk_pte(44'h0_0005_5550, 7'h0B, 1'b1));
    run(va, 4'd8, root, 1'b1, "R9");
    build(va, 4'd8, root, 1, mk_pte(44'h0_0004_0000, 7'h0B, 1'b1));
    run(va, 4'd8, root, 1'b1, "R9");

    // constrained random walks
    for (int t = 0; t < 200; t++) begin
      logic [3:0]  m;
      int          top, ll;
      logic [43:0] ppn;
      logic [63:0] leaf;
      logic [6:0]  pm;
      bit          n, nap;
      logic [2:0]  c;
      logic [55:0] dpa;
      logic [6:0]  dpm;
      int          drd;
      string       tg;
      m    = 4'(8 + $urandom % 3);
      top  = int'(m) - 6;
      ll   = int'($urandom % (top + 1));
      root = {12'h0, $urandom};
      va   = sext({$urandom, $urandom}, 12 + 9 * (top + 1));
      if ($urandom % 10 == 0) va[62] = ~va[62];
      ppn  = {$urandom, $urandom} & 44'hFFF_FFFF_FFFF;
      if (ll > 0 && $urandom % 4 != 0) ppn = (ppn >> (9 * ll)) << (9 * ll);
      pm   = 7'($urandom);
      if (ll > 0 && pm[2:0] == 3'b000) pm[0] = 1'b1;
      n    = (ll == 0) && ($urandom % 3 == 0);
      if (n && $urandom % 4 != 0) ppn[3:0] = 4'b1000;
      nap  = 1'($urandom % 2);
      leaf = mk_pte(ppn, pm, n);
      if ($urandom % 10 == 0) leaf[0] = 1'b0;
      if ($urandom % 20 == 0) m = 4'($urandom);
      build(va, 4'(8 + top), root, ll, leaf);
      model(va, m, root, nap, dpa, dpm, c, drd);
      case (c)
        3'd1: tg = "R2";
        3'd2: tg = "R3";
        3'd3: tg = "R5";
        3'd4: tg = "R7";
        3'd5: tg = "R9";
        default: tg = n ? "R8" : (ll > 0 ? "R7" : "R4");
      endcase
      run(va, m, root, nap, tg);
    end
    chk(n_chk > 12, "R12", "check count", 64'(n_chk), 64'd13);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule